// File: doc/BRIEF.md
# PWM Global Control and Interrupt Section

This block is the shared control section of a small multi-channel pulse-width modulator. A host reaches it over a plain 32-bit register bus with word addresses. Through this bus the host starts and stops channels, chooses which channels may interrupt, and collects end-of-period events. Each channel reports a one-cycle pulse at the end of every one of its periods. The block keeps that pulse as a pending flag until the host acknowledges it, and it drives one combined interrupt line.

Channel enables and interrupt masks have no plain write path. Each has a register that sets bits and a separate register that clears bits, and a 1 acts only on its own bit. Pending events are acknowledged by reading their register: the read returns the flags and clears exactly the ones it returned. The per-channel counters and clock dividers sit outside this block. Those counters receive the enable bits from this block and return the period pulses. The dividers receive the contents of a free-form mode word.

Top module: `pwm_glb_ctrl`

## Requirements
- R1: After reset, and again whenever reset is applied later, every channel is off, the mode word is zero, no interrupt is unmasked, nothing is pending and `irq` is low.
- R2: A write to offset 0x04 turns on channel n for every bit n that is 1. Bits that are 0 leave their channels as they were.
- R3: A write to offset 0x08 turns off channel n for every bit n that is 1. Bits that are 0 leave their channels as they were.
- R4: A read of offset 0x0C returns the current channel enable bits in bits [NCH-1:0], and bits above NCH read as zero.
- R5: A write to offset 0x10 sets mask bits and a write to offset 0x14 clears mask bits, acting on each bit that is 1. The mask reads back at offset 0x18.
- R6: A period pulse on a channel that is enabled becomes a pending flag on the next clock edge. A pulse on a disabled channel is dropped.
- R7: A read of offset 0x1C returns the pending flags and clears them at the clock edge that ends the read.
- R8: A period pulse that arrives in the same cycle as a read of offset 0x1C is not returned by that read. It remains pending and is returned by the next read.
- R9: `irq` is high exactly when some channel has both its pending flag and its mask bit set. Changing the mask changes `irq` without changing the pending flags.
- R10: Offset 0x00 holds a 32-bit mode word that can be read back and is driven unchanged on `mode_cfg`.
- R11: Writes to offsets 0x0C, 0x18, 0x1C, or to any address outside 0x00 to 0x1C (for example, the per-channel windows from 0x200 upward), change nothing. Reads of addresses outside that range return zero. Outside a read, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero outside a read |
| period_evt | input | NCH (4) | One-cycle end-of-period pulse for each channel |
| chan_en | output | NCH (4) | Run enable for each channel |
| mode_cfg | output | 32 | Mode word, passed to the clock dividers |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions can fall in the same cycle: a channel posting a new end-of-period event, and the host reading the pending register to acknowledge earlier events. The bench provokes this by holding a period pulse on one channel during the read of offset 0x1C that acknowledges another channel. It then checks three things: the read returns only the older flag, `irq` stays high for the new event, and the following read returns the new flag. A second overlap tested is a mask change while an event is pending. In that case `irq` must drop while the pending flag survives until its read.

// File: rtl/pwm_glb_pkg.sv
// Package: shared register indices and address geometry for the PWM
// global control section. Assumes 32-bit word-aligned registers.
package pwm_glb_pkg;

    localparam int NREG     = 8;               // registers in the global window
    localparam int IDX_LSB  = 2;               // byte-to-word shift
    localparam int IDX_W    = $clog2(NREG);    // bits selecting a register
    localparam int WIN_BITS = IDX_LSB + IDX_W; // span of the global window
    localparam int DATA_W   = 32;

    typedef enum logic [IDX_W-1:0] {
        RG_MODE = 3'd0,   // mode word
        RG_ENA  = 3'd1,   // channel set
        RG_DIS  = 3'd2,   // channel clear
        RG_STAT = 3'd3,   // channel status
        RG_IEN  = 3'd4,   // mask set
        RG_IDS  = 3'd5,   // mask clear
        RG_IMSK = 3'd6,   // mask readback
        RG_ISTS = 3'd7    // pending, clear on read
    } reg_idx_e;

endpackage

// File: rtl/pwm_glb_decode.sv
// Module: address decoder. Turns one bus access into one-hot read and
// write strobes, one per global register. Assumes word-aligned accesses;
// an access with nonzero low bits, or one outside the global window,
// produces no strobe.
module pwm_glb_decode
    import pwm_glb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NREG-1:0]   wr_hit,
    output logic [NREG-1:0]   rd_hit
);

    localparam int HI_W = ADDR_W - WIN_BITS;

    logic             in_win;
    logic [IDX_W-1:0] idx;

    // Qualify the address: upper bits zero, word aligned.
    always_comb begin
        in_win = (bus_addr[ADDR_W-1:WIN_BITS] == HI_W'(0)) &&
                 (bus_addr[IDX_LSB-1:0] == IDX_LSB'(0));
        idx    = bus_addr[WIN_BITS-1:IDX_LSB];
    end

    // One strobe pair per register.
    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign wr_hit[g] = bus_wr && in_win && (idx == IDX_W'(g));
        assign rd_hit[g] = bus_rd && in_win && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/pwm_glb_setclr.sv
// Module: a bit vector changed only through set and clear strobes.
// A 1 in the set data sets that bit, and a 1 in the clear data clears it.
// Assumes set and clear are not both asserted for the same bit;
// if they are, clear wins.
module pwm_glb_setclr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic [W-1:0] set_bits,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);

    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    // Gate the data with the strobes.
    always_comb begin
        set_m = set_stb ? set_bits : '0;
        clr_m = clr_stb ? clr_bits : '0;
    end

    // Register update: set first, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_m) & ~clr_m;
    end

endmodule

// File: rtl/pwm_glb_evtlatch.sv
// Module: per-channel pending latch and combined interrupt.
// An end-of-period pulse from an enabled channel sets its flag. An
// acknowledge clears only the flags present at that cycle, so a pulse
// that arrives during the acknowledge survives it.
module pwm_glb_evtlatch #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic [NCH-1:0] en,
    input  logic           ack,
    input  logic [NCH-1:0] mask,
    output logic [NCH-1:0] pend,
    output logic           irq
);

    logic [NCH-1:0] evt_q;
    logic [NCH-1:0] ack_m;

    // Qualify the pulses with the enables; build the acknowledge mask.
    always_comb begin
        evt_q = evt & en;
        ack_m = ack ? pend : '0;
    end

    // Pending flags: drop the acknowledged ones, add the new ones.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~ack_m) | evt_q;
    end

    // Combined interrupt from the unmasked pending flags.
    always_comb irq = |(pend & mask);

endmodule

// File: rtl/pwm_glb_ctrl.sv
// Module: top of the PWM global control section. Decodes the register
// bus, holds the mode word, channel enables and interrupt mask, latches
// period events, and returns read data in the same cycle as the read.
// Assumes NCH < 32 and ADDR_W > 5.
module pwm_glb_ctrl
    import pwm_glb_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    period_evt,
    output logic [NCH-1:0]    chan_en,
    output logic [31:0]       mode_cfg,
    output logic              irq
);

    logic [NREG-1:0]   wr_hit;
    logic [NREG-1:0]   rd_hit;
    logic [NCH-1:0]    imask;
    logic [NCH-1:0]    pend;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] rd_word [NREG];

    pwm_glb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    pwm_glb_setclr #(.W(NCH)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (wr_hit[RG_ENA]),
        .set_bits (bus_wdata[NCH-1:0]),
        .clr_stb  (wr_hit[RG_DIS]),
        .clr_bits (bus_wdata[NCH-1:0]),
        .q        (chan_en)
    );

    pwm_glb_setclr #(.W(NCH)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (wr_hit[RG_IEN]),
        .set_bits (bus_wdata[NCH-1:0]),
        .clr_stb  (wr_hit[RG_IDS]),
        .clr_bits (bus_wdata[NCH-1:0]),
        .q        (imask)
    );

    pwm_glb_evtlatch #(.NCH(NCH)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (period_evt),
        .en    (chan_en),
        .ack   (rd_hit[RG_ISTS]),
        .mask  (imask),
        .pend  (pend),
        .irq   (irq)
    );

    // Mode word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)               mode_q <= '0;
        else if (wr_hit[RG_MODE]) mode_q <= bus_wdata;
    end

    assign mode_cfg = mode_q;

    // Readable view of each register; write-only ones read as zero.
    always_comb begin
        rd_word[RG_MODE] = mode_q;
        rd_word[RG_ENA]  = '0;
        rd_word[RG_DIS]  = '0;
        rd_word[RG_STAT] = DATA_W'(chan_en);
        rd_word[RG_IEN]  = '0;
        rd_word[RG_IDS]  = '0;
        rd_word[RG_IMSK] = DATA_W'(imask);
        rd_word[RG_ISTS] = DATA_W'(pend);
    end

    // Read multiplexer: OR of the selected words, zero when idle.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            bus_rdata = bus_rdata | (rd_word[i] & {DATA_W{rd_hit[i]}});
        end
    end

endmodule

// File: rtl/pwm_glb_ctrl_chk.sv
// Module: assertion checker for pwm_glb_ctrl. It observes top-level
// ports only and is attached with the bind below.
module pwm_glb_ctrl_chk #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NCH-1:0]    period_evt,
    input logic [NCH-1:0]    chan_en,
    input logic [31:0]       mode_cfg,
    input logic              irq
);

    logic wr_ena;
    logic wr_dis;
    logic rd_ists;
    logic outside;

    // Recognise the accesses of interest from the raw port values.
    always_comb begin
        wr_ena  = bus_wr && (bus_addr == ADDR_W'(12'h004));
        wr_dis  = bus_wr && (bus_addr == ADDR_W'(12'h008));
        rd_ists = bus_rd && (bus_addr == ADDR_W'(12'h01C));
        outside = (bus_addr[ADDR_W-1:5] != '0);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (chan_en == '0 && mode_cfg == '0 && !irq)); // R1

    AST_ENA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ena |=> ((chan_en & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0]))); // R2

    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis |=> ((chan_en & $past(bus_wdata[NCH-1:0])) == '0)); // R3

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ena || wr_dis) |=> $stable(chan_en)); // R11

    AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(12'h00C)) |-> (bus_rdata[31:NCH] == '0)); // R4

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ists && !bus_wr && period_evt == '0) |=> !irq); // R7

    AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd && outside) || !bus_rd) |-> (bus_rdata == '0)); // R11

endmodule

bind pwm_glb_ctrl pwm_glb_ctrl_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .period_evt (period_evt),
    .chan_en    (chan_en),
    .mode_cfg   (mode_cfg),
    .irq        (irq)
);

// File: tb/pwm_glb_ctrl_bench.sv
`timescale 1ns/100ps
// Bench: a vector table walked by one loop, then directed tests for
// overlapping events and acknowledges, mask changes and reset.
module pwm_glb_ctrl_bench;

    localparam int NCH    = 4;
    localparam int ADDR_W = 12;
    localparam logic [1:0] K_IDLE = 2'd0, K_WR = 2'd1, K_RD = 2'd2;

    typedef struct packed {
        logic [1:0]        kind;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
        logic [NCH-1:0]    evt;
        logic [31:0]       exp;
        logic              exp_irq;
        logic [7:0]        req;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VEC [NVEC] = '{
        '{K_WR,   12'h004, 32'h5,         4'h0, 32'h0,         1'b0, 8'd2},  // R2
        '{K_RD,   12'h00C, 32'h0,         4'h0, 32'h5,         1'b0, 8'd2},  // R2
        '{K_WR,   12'h004, 32'h2,         4'h0, 32'h0,         1'b0, 8'd2},  // R2
        '{K_RD,   12'h00C, 32'h0,         4'h0, 32'h7,         1'b0, 8'd2},  // R2
        '{K_WR,   12'h008, 32'h4,         4'h0, 32'h0,         1'b0, 8'd3},  // R3
        '{K_RD,   12'h00C, 32'h0,         4'h0, 32'h3,         1'b0, 8'd4},  // R3 R4
        '{K_WR,   12'h010, 32'h3,         4'h0, 32'h0,         1'b0, 8'd5},  // R5
        '{K_WR,   12'h014, 32'h1,         4'h0, 32'h0,         1'b0, 8'd5},  // R5
        '{K_RD,   12'h018, 32'h0,         4'h0, 32'h2,         1'b0, 8'd5},  // R5
        '{K_IDLE, 12'h000, 32'h0,         4'hD, 32'h0,         1'b0, 8'd6},  // R6
        '{K_IDLE, 12'h000, 32'h0,         4'h2, 32'h0,         1'b1, 8'd9},  // R9
        '{K_RD,   12'h01C, 32'h0,         4'h0, 32'h3,         1'b0, 8'd7},  // R7
        '{K_RD,   12'h01C, 32'h0,         4'h0, 32'h0,         1'b0, 8'd7},  // R7
        '{K_WR,   12'h000, 32'hA5A50102,  4'h0, 32'h0,         1'b0, 8'd10}, // R10
        '{K_RD,   12'h000, 32'h0,         4'h0, 32'hA5A50102,  1'b0, 8'd10}, // R10
        '{K_WR,   12'h200, 32'hF,         4'h0, 32'h0,         1'b0, 8'd11}, // R11
        '{K_RD,   12'h200, 32'h0,         4'h0, 32'h0,         1'b0, 8'd11}, // R11
        '{K_WR,   12'h00C, 32'hF,         4'h0, 32'h0,         1'b0, 8'd11}, // R11
        '{K_RD,   12'h00C, 32'h0,         4'h0, 32'h3,         1'b0, 8'd11}, // R11
        '{K_WR,   12'h018, 32'hF,         4'h0, 32'h0,         1'b0, 8'd11}, // R11
        '{K_RD,   12'h018, 32'h0,         4'h0, 32'h2,         1'b0, 8'd11}, // R11
        '{K_RD,   12'h020, 32'h0,         4'h0, 32'h0,         1'b0, 8'd11}  // R11
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    period_evt = '0;
    logic [NCH-1:0]    chan_en;
    logic [31:0]       mode_cfg;
    logic              irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_glb_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) u_pwm_glb_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .period_evt (period_evt),
        .chan_en    (chan_en),
        .mode_cfg   (mode_cfg),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample read data before
    // the rising edge, sample irq just after it, then return to idle.
    task automatic cyc(input logic [1:0] kind, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input logic [NCH-1:0] ev,
                       output logic [31:0] rdv, output logic irqv);
        @(negedge clk);
        bus_wr     = (kind == K_WR);
        bus_rd     = (kind == K_RD);
        bus_addr   = a;
        bus_wdata  = d;
        period_evt = ev;
        #1;
        rdv = bus_rdata;
        @(posedge clk);
        #0.5;
        irqv       = irq;
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        period_evt = '0;
    endtask

    initial begin : main
        logic [31:0] rv;
        logic        iv;
        repeat (3) @(posedge clk);
        #0.5;
        rst_n = 1'b1;
        // R1: reset state
        check("R1 chan_en", 32'(chan_en), 32'h0);
        check("R1 mode_cfg", mode_cfg, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        cyc(K_RD, 12'h018, 0, 0, rv, iv); check("R1 mask", rv, 32'h0);
        cyc(K_RD, 12'h01C, 0, 0, rv, iv); check("R1 pending", rv, 32'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            cyc(VEC[i].kind, VEC[i].addr, VEC[i].data, VEC[i].evt, rv, iv);
            if (VEC[i].kind == K_RD)
                check($sformatf("R%0d rdata vec %0d", VEC[i].req, i), rv, VEC[i].exp);
            check($sformatf("R%0d irq vec %0d", VEC[i].req, i), 32'(iv), 32'(VEC[i].exp_irq));
        end
        check("R2 chan_en port", 32'(chan_en), 32'h3);
        check("R10 mode_cfg port", mode_cfg, 32'hA5A50102);

        // R8: event on ch1 during the acknowledge of ch0 (mask = 0010)
        cyc(K_IDLE, 0, 0, 4'h1, rv, iv);
        cyc(K_RD, 12'h01C, 0, 4'h2, rv, iv);
        check("R8 read returns old only", rv, 32'h1);
        check("R8 irq from surviving event", 32'(iv), 32'h1);
        // R9: masking drops irq, pending kept
        cyc(K_WR, 12'h014, 32'h2, 0, rv, iv);
        check("R9 irq after mask clear", 32'(iv), 32'h0);
        cyc(K_RD, 12'h01C, 0, 0, rv, iv);
        check("R8 survivor read next", rv, 32'h2);

        // R1: reset during operation
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        check("R1 chan_en after rerun reset", 32'(chan_en), 32'h0);
        check("R1 mode_cfg after rerun reset", mode_cfg, 32'h0);
        cyc(K_RD, 12'h018, 0, 0, rv, iv); check("R1 mask after rerun reset", rv, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule